// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive buffer descriptors held in system memory. Each descriptor is four 16-bit words. When the receive side asks for a new buffer, the fetcher reads the descriptor at its read pointer through a single-beat memory read port. It loads the descriptor into a buffer-address register and a buffer-size register, then moves the read pointer on to the next descriptor. The pointer wraps back to the ring start when it reaches the ring end. A sticky status bit is raised when the ring has no descriptors left to give.

The ring is bounded by a start pointer and an end pointer. A separate write pointer marks where the host stops adding descriptors. All four pointers are 16 bits wide and are written by the host. A fifth host register supplies address bits 31:16 for every descriptor access. A mode input selects a 16-bit or a 32-bit memory layout. In the 32-bit layout every descriptor word sits in the low half of a 32-bit location.

A completed fetch also clears the "last buffer full" flag, which is raised by the receive logic when it runs out of space. Clearing that flag lets reception continue.

Top module: `rx_ring_fetch`

## Requirements
- R1: A fetch reads four 16-bit words. The first word goes to `buf_addr[15:0]`, the second to `buf_addr[31:16]`, the third to `buf_words[15:0]` and the fourth to `buf_words[31:16]`. All four are in place by the cycle in which `done` is high.
- R2: Word k of a fetch (k = 0..3) is requested at address {upper, rd_ptr} + 2k when `cfg_wide`=0, and at {upper, rd_ptr} + 4k when `cfg_wide`=1.
- R3: On completion the read pointer advances by 8 when `cfg_wide`=0 and by 16 when `cfg_wide`=1. The new value is visible in the `done` cycle.
- R4: If the advanced pointer equals the end pointer, the read pointer takes the start pointer value instead.
- R5: If the pointer after advance and wrap equals the write pointer, `exhausted` goes high in the `done` cycle. It stays high until a cycle with `exh_clr`=1 and no new exhaustion.
- R6: `hw_sel` selects the host register: 0 is start, 1 is end, 2 is read, 3 is write, 4 is upper. Writes to registers 0..3 are masked with 0xFFFC when `cfg_wide`=1 and with 0xFFFE when `cfg_wide`=0. The upper register takes all 16 bits.
- R7: `full_set` raises `last_full`, and a completed fetch clears it.
- R8: `busy` is high from the cycle after an accepted `fetch_req` until the fourth word returns. `done` is high for exactly one cycle per fetch. `mem_req_valid` is only high while `busy` is high.
- R9: A `fetch_req` that arrives while busy is held. The held fetch runs right after the current one, so `busy` stays high in the `done` cycle. Host writes to the read and upper registers are dropped while busy.
- R10: After reset `busy`, `done`, `exhausted`, `last_full`, `mem_req_valid` and every pointer read zero.
- R11: A memory request that is not yet accepted keeps `mem_req_valid` high and `mem_req_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 selects the 32-bit memory layout, 0 the 16-bit layout |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 3 | Host register select (0 start, 1 end, 2 read, 3 write, 4 upper) |
| hw_data | input | 16 | Host write data |
| fetch_req | input | 1 | Request to fetch the next descriptor |
| exh_clr | input | 1 | Clears the exhausted status bit |
| full_set | input | 1 | Raises the last-buffer-full flag |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 16 | Memory read data |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | One-cycle pulse when a fetch completes |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Current buffer size in 16-bit words |
| rd_ptr | output | 16 | Ring read pointer |
| start_ptr | output | 16 | Ring start pointer |
| end_ptr | output | 16 | Ring end pointer |
| wr_ptr | output | 16 | Ring write pointer |
| upper_addr | output | 16 | Descriptor address bits 31:16 |
| exhausted | output | 1 | Sticky no-buffers-left status |
| last_full | output | 1 | Last-buffer-full flag |

## Verification
A wrong word counter appears on `mem_req_addr` at the very next request, and it puts a descriptor half into the wrong register by the `done` cycle. A bad advance, wrap or exhaustion compare appears on `rd_ptr` and `exhausted` in the `done` cycle itself. Every one of these is visible at the ports no later than the end of the fetch that caused it. Losing a held request shows up one fetch later, as a missing second `done` and a pointer that stops one step short.

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch #(
  parameter int PTR_W = 16,
  parameter int DAT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wide,
  input  logic                 hw_en,
  input  logic [2:0]           hw_sel,
  input  logic [PTR_W-1:0]     hw_data,
  input  logic                 fetch_req,
  input  logic                 exh_clr,
  input  logic                 full_set,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [2*PTR_W-1:0]   mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [DAT_W-1:0]     mem_rsp_data,
  output logic                 busy,
  output logic                 done,
  output logic [2*DAT_W-1:0]   buf_addr,
  output logic [2*DAT_W-1:0]   buf_words,
  output logic [PTR_W-1:0]     rd_ptr,
  output logic [PTR_W-1:0]     start_ptr,
  output logic [PTR_W-1:0]     end_ptr,
  output logic [PTR_W-1:0]     wr_ptr,
  output logic [PTR_W-1:0]     upper_addr,
  output logic                 exhausted,
  output logic                 last_full
);

  localparam int ADR_W    = 2 * PTR_W;
  localparam int NWORD    = 4;
  localparam int IDX_W    = $clog2(NWORD);
  localparam int STEP_N   = NWORD * 2;
  localparam int STEP_W   = NWORD * 4;
  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_RD    = 3'd2;
  localparam logic [2:0] SEL_WR    = 3'd3;
  localparam logic [2:0] SEL_UP    = 3'd4;

  logic             pend_q, issued_q;
  logic [IDX_W-1:0] idx_q;

  wire [PTR_W-1:0] amask = cfg_wide ? ~PTR_W'(3) : ~PTR_W'(1);
  wire [PTR_W-1:0] wdat  = hw_data & amask;
  wire [ADR_W-1:0] woff  = cfg_wide ? (ADR_W'(idx_q) << 2) : (ADR_W'(idx_q) << 1);
  wire [PTR_W-1:0] step  = cfg_wide ? PTR_W'(STEP_W) : PTR_W'(STEP_N);
  wire [PTR_W-1:0] adv   = rd_ptr + step;
  wire [PTR_W-1:0] nxt   = (adv == end_ptr) ? start_ptr : adv;
  wire             beat  = busy && mem_rsp_valid;
  wire             last  = beat && (idx_q == IDX_W'(NWORD - 1));
  wire             wr_ok = hw_en && !busy;

  assign mem_req_valid = busy && !issued_q;
  assign mem_req_addr  = {upper_addr, rd_ptr} + woff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend_q   <= 1'b0;
      issued_q <= 1'b0;
      idx_q    <= '0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
      if (beat) begin
        issued_q <= 1'b0;
        idx_q    <= idx_q + 1'b1;
      end
      if (!busy) begin
        busy <= fetch_req;
      end else if (last) begin
        busy   <= pend_q || fetch_req;
        pend_q <= 1'b0;
      end else if (fetch_req) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr  <= '0;
      buf_words <= '0;
    end else if (beat) begin
      case (idx_q)
        2'd0:    buf_addr[DAT_W-1:0]        <= mem_rsp_data;
        2'd1:    buf_addr[2*DAT_W-1:DAT_W]  <= mem_rsp_data;
        2'd2:    buf_words[DAT_W-1:0]       <= mem_rsp_data;
        default: buf_words[2*DAT_W-1:DAT_W] <= mem_rsp_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ptr  <= '0;
      end_ptr    <= '0;
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      upper_addr <= '0;
    end else begin
      if (hw_en && hw_sel == SEL_START) start_ptr  <= wdat;
      if (hw_en && hw_sel == SEL_END)   end_ptr    <= wdat;
      if (hw_en && hw_sel == SEL_WR)    wr_ptr     <= wdat;
      if (wr_ok && hw_sel == SEL_UP)    upper_addr <= hw_data;
      if (last)                         rd_ptr     <= nxt;
      else if (wr_ok && hw_sel == SEL_RD) rd_ptr   <= wdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exhausted <= 1'b0;
      last_full <= 1'b0;
    end else begin
      if (last && nxt == wr_ptr) exhausted <= 1'b1;
      else if (exh_clr)          exhausted <= 1'b0;
      if (last)                  last_full <= 1'b0;
      else if (full_set)         last_full <= 1'b1;
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r5_exh_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exhausted) |-> done);

  a_r6_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr[0] == 1'b0);

endmodule

// File: tb/rx_ring_fetch_test.sv
module rx_ring_fetch_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        hw_en = 1'b0;
  logic [2:0]  hw_sel = 3'd0;
  logic [15:0] hw_data = 16'd0;
  logic        fetch_req = 1'b0;
  logic        exh_clr = 1'b0;
  logic        full_set = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = 16'd0;
  logic        busy, done, exhausted, last_full;
  logic [31:0] buf_addr, buf_words;
  logic [15:0] rd_ptr, start_ptr, end_ptr, wr_ptr, upper_addr;

  int compared = 0;
  int mismatched = 0;
  int hs_count = 0;
  logic [31:0] last_req = 32'd0;
  logic [3:0]  ready_pat = 4'b1011;

  always #5 clk = ~clk;

  rx_ring_fetch uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .hw_en(hw_en),
    .hw_sel(hw_sel), .hw_data(hw_data), .fetch_req(fetch_req),
    .exh_clr(exh_clr), .full_set(full_set), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .buf_addr(buf_addr), .buf_words(buf_words),
    .rd_ptr(rd_ptr), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .wr_ptr(wr_ptr), .upper_addr(upper_addr), .exhausted(exhausted),
    .last_full(last_full)
  );

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    ready_pat     <= {ready_pat[2:0], ready_pat[3]};
    mem_req_ready <= ready_pat[3];
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_word(mem_req_addr);
      last_req      <= mem_req_addr;
      hs_count      <= hs_count + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_sel = sel; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (done !== 1'b1) check(req, 32'd0, 32'd1);
  endtask

  // wide, upper, start, end, rd, wr, expected rd, expected exhausted
  localparam logic [97:0] VEC [6] = '{
    {1'b0, 16'h0001, 16'h0100, 16'h0140, 16'h0100, 16'h0000, 16'h0108, 1'b0},
    {1'b0, 16'h0002, 16'h0100, 16'h0140, 16'h0138, 16'h0200, 16'h0100, 1'b0},
    {1'b1, 16'h0003, 16'h0200, 16'h0300, 16'h0200, 16'h0210, 16'h0210, 1'b1},
    {1'b1, 16'h0004, 16'h0200, 16'h0300, 16'h02F0, 16'h0200, 16'h0200, 1'b1},
    {1'b0, 16'h0005, 16'h0100, 16'h0140, 16'h0100, 16'h0108, 16'h0108, 1'b1},
    {1'b1, 16'hABCD, 16'h0200, 16'h0300, 16'h0400, 16'h0000, 16'h0410, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy", {31'd0, busy}, 32'd0);
    check("R10 done", {31'd0, done}, 32'd0);
    check("R10 exhausted", {31'd0, exhausted}, 32'd0);
    check("R10 last_full", {31'd0, last_full}, 32'd0);
    check("R10 req_valid", {31'd0, mem_req_valid}, 32'd0);
    check("R10 pointers", {16'd0, rd_ptr | start_ptr | end_ptr | wr_ptr | upper_addr}, 32'd0);

    for (int v = 0; v < 6; v++) begin
      logic        wd;
      logic [15:0] up, st, en, rp, wp, erd;
      logic        eex;
      logic [31:0] a0, s;
      int          hs0;
      {wd, up, st, en, rp, wp, erd, eex} = VEC[v];
      cfg_wide = wd;
      host_wr(3'd4, up);
      host_wr(3'd0, st);
      host_wr(3'd1, en);
      host_wr(3'd2, rp);
      host_wr(3'd3, wp);
      @(negedge clk); exh_clr = 1'b1;
      @(negedge clk); exh_clr = 1'b0; full_set = 1'b1;
      @(negedge clk); full_set = 1'b0;
      check("R7 full raised", {31'd0, last_full}, 32'd1);
      a0  = {up, rp};
      s   = wd ? 32'd4 : 32'd2;
      hs0 = hs_count;
      pulse_req();
      check("R8 busy during fetch", {31'd0, busy}, 32'd1);
      wait_done("R8 done seen");
      check("R1 buf_addr", buf_addr, {mem_word(a0 + s), mem_word(a0)});
      check("R1 buf_words", buf_words, {mem_word(a0 + 3 * s), mem_word(a0 + 2 * s)});
      check("R2 word3 address", last_req, a0 + 3 * s);
      check("R2 four reads", hs_count - hs0, 32'd4);
      check("R3/R4 rd_ptr", {16'd0, rd_ptr}, {16'd0, erd});
      check("R5 exhausted", {31'd0, exhausted}, {31'd0, eex});
      check("R7 full cleared", {31'd0, last_full}, 32'd0);
      check("R8 busy low at done", {31'd0, busy}, 32'd0);
      @(negedge clk);
      check("R8 done single cycle", {31'd0, done}, 32'd0);
    end

    // R5: exhausted stays until cleared
    repeat (3) @(negedge clk);
    check("R5 exhausted sticky", {31'd0, exhausted}, 32'd0);
    cfg_wide = 1'b0;
    host_wr(3'd2, 16'h0100);
    host_wr(3'd3, 16'h0108);
    pulse_req();
    wait_done("R5 done seen");
    repeat (4) @(negedge clk);
    check("R5 exhausted held", {31'd0, exhausted}, 32'd1);
    @(negedge clk); exh_clr = 1'b1;
    @(negedge clk); exh_clr = 1'b0;
    check("R5 exhausted cleared", {31'd0, exhausted}, 32'd0);

    // R6: masking per mode
    cfg_wide = 1'b1;
    host_wr(3'd0, 16'hFFFF);
    check("R6 wide mask", {16'd0, start_ptr}, 32'h0000FFFC);
    cfg_wide = 1'b0;
    host_wr(3'd1, 16'hFFFF);
    check("R6 narrow mask", {16'd0, end_ptr}, 32'h0000FFFE);
    host_wr(3'd4, 16'hFFFF);
    check("R6 upper unmasked", {16'd0, upper_addr}, 32'h0000FFFF);

    // R9: held request and dropped read-pointer write
    host_wr(3'd0, 16'h0100);
    host_wr(3'd1, 16'h0140);
    host_wr(3'd2, 16'h0100);
    host_wr(3'd3, 16'h0000);
    host_wr(3'd4, 16'h0007);
    pulse_req();
    @(negedge clk);
    fetch_req = 1'b1; hw_en = 1'b1; hw_sel = 3'd2; hw_data = 16'h0020;
    @(negedge clk);
    fetch_req = 1'b0; hw_en = 1'b0;
    wait_done("R9 first done");
    check("R9 first rd_ptr", {16'd0, rd_ptr}, 32'h00000108);
    check("R9 busy held", {31'd0, busy}, 32'd1);
    @(negedge clk);
    wait_done("R9 second done");
    check("R9 second rd_ptr", {16'd0, rd_ptr}, 32'h00000110);
    check("R9 second buf_addr", buf_addr,
          {mem_word(32'h00070108 + 2), mem_word(32'h00070108)});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule